// File: doc/BRIEF.md
# Stepper Driver Fault and Sleep Supervisor

This block is the digital supervisor of a stepper-motor driver. It folds thermal, overcurrent, open-coil and charge-pump fault flags into one error request that pulls an open-drain, active-low error pin. It holds a small register file that a serial-port slave reads and writes through a plain parallel port. One control bit selects a low-power sleep state.

In sleep the power stage is forced to high impedance and the analog section is switched off. Step pulses and direction changes are ignored, and the local clock is enabled only while the serial port is selected. Register contents are kept, and register access still works. After sleep is cleared, step pulses stay blocked for a fixed settle interval so that the charge pump can recover.

A level-sensitive clear input resets every register, but only once it has been held high for a qualifying number of clock cycles. The charge pump stays enabled whenever that input is high.

Top module: `stepper_supervisor`

## Requirements
- R1: `err_pd_o` is 1 in the same cycle that any of `therm_warn_i`, `therm_shut_i`, a bit of `ovc_x_i`, a bit of `ovc_y_i` or a bit of `open_coil_i` is 1, and it is 1 whenever the charge-pump failure bit is 1. Otherwise it is 0.
- R2: Address 0 reads a status byte in the same cycle: bit 0 is the charge-pump failure bit, bit 1 is thermal warning, bit 2 is thermal shutdown, bit 3 is the OR of all overcurrent flags, bit 4 is the OR of all open-coil flags, and bits 7:5 are 0. Writes to address 0 have no effect.
- R3: The charge-pump failure bit is 1 after power-on reset. On each clock edge it takes the inverse of `cp_ready_i`, so it is 0 one cycle after the input rises and 1 again one cycle after the input drops.
- R4: A write at address 1 stores all 8 bits. A write at address 2 stores all 8 bits, and bit 0 of that register is the sleep bit. Both registers read back what was written, in the cycle after the write edge. Address 3 reads 0.
- R5: While the sleep bit is 1, `drv_hiz_o` is 1, `analog_en_o` is 0, and `cp_en_o` is 0 unless `clr_i` is 1. Register reads and writes keep working in sleep.
- R6: While the sleep bit is 1, `step_o` is 0 and `dir_o` holds the value `dir_i` had in the last cycle before sleep. While awake and ready, `step_o` follows `step_i` and `dir_o` follows `dir_i`.
- R7: `clk_en_o` is 1 when the sleep bit is 0 or when `spi_sel_i` is 1, and 0 otherwise.
- R8: A write at edge E that clears a set sleep bit drops `wake_ready_o` and blocks `step_o` until edge E+STARTUP_CYCLES. From then on `wake_ready_o` is 1 and `step_o` follows `step_i`.
- R9: If `clr_i` is high at CLR_MIN consecutive clock edges, the clear applies at the last of those edges and at every further edge while the input stays high. It zeroes both control registers, sets the charge-pump failure bit to 1, ends any wake interval and zeroes the held direction. Register writes during a qualified clear are ignored. A high pulse spanning fewer edges changes nothing.
- R10: `cp_en_o` is 1 whenever `clr_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_i | input | 1 | Level-held hard clear, active high |
| spi_sel_i | input | 1 | Serial port selected (chip select asserted) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| therm_warn_i | input | 1 | Thermal warning flag |
| therm_shut_i | input | 1 | Thermal shutdown flag |
| ovc_x_i | input | N_OVC | X-bridge overcurrent flags |
| ovc_y_i | input | N_OVC | Y-bridge overcurrent flags |
| open_coil_i | input | N_COIL | Open-coil flags |
| cp_ready_i | input | 1 | Charge pump above its threshold |
| step_i | input | 1 | Step request |
| dir_i | input | 1 | Direction request |
| step_o | output | 1 | Gated step to the sequencer |
| dir_o | output | 1 | Gated direction |
| err_pd_o | output | 1 | Pull-down enable for the open-drain error pin |
| drv_hiz_o | output | 1 | Force the power stage to high impedance |
| analog_en_o | output | 1 | Analog section enable |
| cp_en_o | output | 1 | Charge pump enable |
| clk_en_o | output | 1 | Local clock enable |
| wake_ready_o | output | 1 | Step pulses accepted |

## Verification
The error output, the status byte, the read data, the step and direction gating and the clock enable are combinational from the inputs and the register state. The bench therefore checks them one time step after it drives the inputs, with no clock edge in between. The charge-pump failure bit and the register writes take effect at the next edge, so the bench advances exactly one edge and checks before any further edge. For the wake interval the bench counts edges from the write and expects the ready flag to be low after each of the first STARTUP_CYCLES-1 edges and high after edge STARTUP_CYCLES. For the clear, it compares a pulse spanning CLR_MIN-1 edges with one spanning CLR_MIN edges.

// File: rtl/stepper_supervisor.sv
`timescale 1ns/1ps
module stepper_supervisor #(
  parameter int ADDR_W         = 2,
  parameter int N_OVC          = 4,
  parameter int N_COIL         = 2,
  parameter int CLR_MIN        = 8,
  parameter int STARTUP_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              spi_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              therm_warn_i,
  input  logic              therm_shut_i,
  input  logic [N_OVC-1:0]  ovc_x_i,
  input  logic [N_OVC-1:0]  ovc_y_i,
  input  logic [N_COIL-1:0] open_coil_i,
  input  logic              cp_ready_i,
  input  logic              step_i,
  input  logic              dir_i,
  output logic              step_o,
  output logic              dir_o,
  output logic              err_pd_o,
  output logic              drv_hiz_o,
  output logic              analog_en_o,
  output logic              cp_en_o,
  output logic              clk_en_o,
  output logic              wake_ready_o
);
  localparam int CLR_W  = $clog2(CLR_MIN + 1);
  localparam int WAKE_W = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CLR_W-1:0]  CLR_TOP  = CLR_W'(CLR_MIN - 1);
  localparam logic [WAKE_W-1:0] WAKE_TOP = WAKE_W'(STARTUP_CYCLES);

  logic [7:0]        ctrl1_q, ctrl2_q;
  logic              cp_fail_q, dir_hold_q;
  logic [CLR_W-1:0]  clr_cnt_q;
  logic [WAKE_W-1:0] wake_cnt_q;

  wire sleep_q  = ctrl2_q[0];
  wire hard_clr = clr_i && (clr_cnt_q == CLR_TOP);
  wire any_ovc  = |{ovc_x_i, ovc_y_i};
  wire any_open = |open_coil_i;
  wire [7:0] status = {3'b000, any_open, any_ovc, therm_shut_i, therm_warn_i, cp_fail_q};
  wire wr1 = reg_wr_i && (reg_addr_i == ADDR_W'(1));
  wire wr2 = reg_wr_i && (reg_addr_i == ADDR_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          clr_cnt_q <= '0;
    else if (!clr_i)     clr_cnt_q <= '0;
    else if (!hard_clr)  clr_cnt_q <= clr_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q    <= '0;
      ctrl2_q    <= '0;
      cp_fail_q  <= 1'b1;
      dir_hold_q <= 1'b0;
      wake_cnt_q <= '0;
    end else if (hard_clr) begin
      ctrl1_q    <= '0;
      ctrl2_q    <= '0;
      cp_fail_q  <= 1'b1;
      dir_hold_q <= 1'b0;
      wake_cnt_q <= '0;
    end else begin
      cp_fail_q <= !cp_ready_i;
      if (!sleep_q) dir_hold_q <= dir_i;
      if (wr1) ctrl1_q <= reg_wdata_i;
      if (wr2) ctrl2_q <= reg_wdata_i;
      if (wr2 && sleep_q && !reg_wdata_i[0]) wake_cnt_q <= WAKE_TOP;
      else if (wake_cnt_q != '0)             wake_cnt_q <= wake_cnt_q - 1'b1;
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_W'(0): reg_rdata_o = status;
      ADDR_W'(1): reg_rdata_o = ctrl1_q;
      ADDR_W'(2): reg_rdata_o = ctrl2_q;
      default:    reg_rdata_o = 8'h00;
    endcase
  end

  assign err_pd_o     = therm_warn_i | therm_shut_i | any_ovc | any_open | cp_fail_q;
  assign wake_ready_o = (wake_cnt_q == '0);
  assign step_o       = step_i & !sleep_q & wake_ready_o;
  assign dir_o        = sleep_q ? dir_hold_q : dir_i;
  assign drv_hiz_o    = sleep_q;
  assign analog_en_o  = !sleep_q;
  assign cp_en_o      = !sleep_q | clr_i;
  assign clk_en_o     = !sleep_q | spi_sel_i;

  assert_fault_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_shut_i || any_ovc || any_open) |-> err_pd_o);
  assert_cp_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_ready_i && !hard_clr) |=> (err_pd_o && reg_rdata_o[0] == 1'b1) || reg_addr_i != '0 || err_pd_o);
  assert_wr1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && !clr_i) |=> ctrl1_q == $past(reg_wdata_i));
  assert_sleep_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hiz_o |-> !step_o);
  assert_clk_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hiz_o && !spi_sel_i) |-> !clk_en_o);
  assert_wake_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep_q) && !$past(clr_i)) |-> !wake_ready_o);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> (ctrl1_q == 8'h00) && !drv_hiz_o && wake_ready_o);
  assert_cp_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> cp_en_o);
endmodule

// File: tb/stepper_supervisor_tb_top.sv
`timescale 1ns/1ps
module stepper_supervisor_tb_top;
  localparam int ADDR_W = 2, N_OVC = 4, N_COIL = 2, CLR_MIN = 8, STARTUP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_i = 1'b0, spi_sel_i = 1'b0, reg_wr_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic therm_warn_i = 1'b0, therm_shut_i = 1'b0, cp_ready_i = 1'b0;
  logic [N_OVC-1:0] ovc_x_i = '0, ovc_y_i = '0;
  logic [N_COIL-1:0] open_coil_i = '0;
  logic step_i = 1'b0, dir_i = 1'b0;
  logic step_o, dir_o, err_pd_o, drv_hiz_o, analog_en_o, cp_en_o, clk_en_o, wake_ready_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  stepper_supervisor #(.ADDR_W(ADDR_W), .N_OVC(N_OVC), .N_COIL(N_COIL),
                       .CLR_MIN(CLR_MIN), .STARTUP_CYCLES(STARTUP)) dut_i (
    .clk, .rst_n, .clr_i, .spi_sel_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .therm_warn_i, .therm_shut_i, .ovc_x_i, .ovc_y_i, .open_coil_i, .cp_ready_i,
    .step_i, .dir_i, .step_o, .dir_o, .err_pd_o, .drv_hiz_o, .analog_en_o, .cp_en_o,
    .clk_en_o, .wake_ready_o);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_wr_i = 1'b0;
    #1;
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1;
    check(req, reg_rdata_o, exp);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    rd("R3 reset cp fail", 0, 8'h01);
    check("R1 reset err", err_pd_o, 1);
    rst_n = 1'b1;
    tick();
    rd("R3 held until ready", 0, 8'h01);
    check("R8 ready after reset", wake_ready_o, 1);
    check("R5 awake hiz", drv_hiz_o, 0);
    cp_ready_i = 1'b1;
    #1;
    rd("R3 not before edge", 0, 8'h01);
    tick();
    rd("R3 clears after edge", 0, 8'h00);
    check("R1 no fault", err_pd_o, 0);
    cp_ready_i = 1'b0;
    tick();
    rd("R3 sets on drop", 0, 8'h01);
    check("R1 cp fail err", err_pd_o, 1);
    cp_ready_i = 1'b1;
    tick();

    reg_addr_i = '0;
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] b;
      b = 12'(v);
      therm_warn_i = b[0]; therm_shut_i = b[1];
      ovc_x_i = b[5:2]; ovc_y_i = b[9:6]; open_coil_i = b[11:10];
      #1;
      check("R1 sweep", err_pd_o, (b != 0));
      check("R2 sweep", reg_rdata_o,
            {27'd0, |b[11:10], |b[9:2], b[1], b[0], 1'b0});
    end
    therm_warn_i = 0; therm_shut_i = 0; ovc_x_i = 0; ovc_y_i = 0; open_coil_i = 0;

    wr(0, 8'hFF);
    rd("R2 status write ignored", 0, 8'h00);
    rd("R4 addr1 untouched", 1, 8'h00);
    rd("R4 addr2 untouched", 2, 8'h00);
    check("R2 no sleep from addr0", drv_hiz_o, 0);
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v));
      rd("R4 ctrl1 readback", 1, 8'(v));
    end
    wr(2, 8'hA4);
    rd("R4 ctrl2 readback", 2, 8'hA4);
    rd("R4 addr3 zero", 3, 8'h00);

    step_i = 1; dir_i = 1;
    #1;
    check("R6 awake step", step_o, 1);
    check("R6 awake dir", dir_o, 1);
    check("R7 awake clk", clk_en_o, 1);
    step_i = 0;
    tick();

    wr(2, 8'hA5);
    check("R5 hiz", drv_hiz_o, 1);
    check("R5 analog off", analog_en_o, 0);
    check("R5 cp off", cp_en_o, 0);
    step_i = 1; dir_i = 0;
    #1;
    check("R6 step blocked", step_o, 0);
    check("R6 dir held", dir_o, 1);
    tick();
    check("R6 dir still held", dir_o, 1);
    spi_sel_i = 0;
    #1;
    check("R7 sleep no sel", clk_en_o, 0);
    spi_sel_i = 1;
    #1;
    check("R7 sleep sel", clk_en_o, 1);
    wr(1, 8'h5A);
    rd("R5 write in sleep", 1, 8'h5A);
    rd("R5 ctrl2 kept", 2, 8'hA5);
    spi_sel_i = 0;

    wr(2, 8'hA4);
    check("R8 ready low at write", wake_ready_o, 0);
    check("R8 step blocked at write", step_o, 0);
    check("R5 hiz off", drv_hiz_o, 0);
    for (int k = 1; k < STARTUP; k++) begin
      tick();
      check("R8 window", {wake_ready_o, step_o}, 2'b00);
    end
    tick();
    check("R8 ready", wake_ready_o, 1);
    check("R8 step passes", step_o, 1);
    step_i = 0;

    wr(1, 8'hC3);
    wr(2, 8'h01);
    clr_i = 1;
    #1;
    check("R10 cp on clear in sleep", cp_en_o, 1);
    for (int k = 1; k < CLR_MIN; k++) begin
      tick();
      check("R10 cp on while clr", cp_en_o, 1);
    end
    clr_i = 0;
    tick();
    rd("R9 short pulse ctrl1", 1, 8'hC3);
    check("R9 short pulse sleep", drv_hiz_o, 1);

    clr_i = 1;
    for (int k = 0; k < CLR_MIN; k++) tick();
    rd("R9 ctrl1 cleared", 1, 8'h00);
    rd("R9 ctrl2 cleared", 2, 8'h00);
    rd("R9 cp fail set", 0, 8'h01);
    check("R9 wake ready", wake_ready_o, 1);
    check("R10 cp on", cp_en_o, 1);
    wr(1, 8'h3C);
    clr_i = 0;
    rd("R9 write ignored", 1, 8'h00);
    dir_i = 0;
    tick();
    rd("R3 recovers after clear", 0, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule